// File: doc/BRIEF.md
# Write-Through Snooping Data Cache with Valid/Invalid Coherence

This block is a small direct-mapped data cache that sits between one core and a shared memory bus. Every line holds a single word and is either valid or invalid; no other coherence state exists. Reads that hit return the stored word. Reads that miss fetch the word from memory and install it.

Writes are always sent through to memory. For each write, the cache requests the shared bus from an arbiter and waits for the grant. It then drives the write address and data onto a broadcast channel. Main memory consumes the channel, and every other cache sees it as a snoop. The cache itself watches a snoop input that carries writes issued by its peers. A snooped address that matches a valid line clears that line, so the next local read misses and fetches the current value from memory.

Write misses do not allocate a line. The core sees a single-request interface: a ready output that is low while an operation is outstanding, and a one-cycle done pulse that carries the read data.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset `core_ready` is 1, `bus_req`, `bus_wvalid` and `mem_rd_req` are 0, and every line is invalid, so the first read of any address misses.
- R2: A write raises `bus_req` and never asserts `bus_wvalid` unless `bus_gnt` is high.
- R3: A snooped write (`snp_valid`) whose address matches a valid line invalidates that line. The next read of that address misses and returns the value memory holds.
- R4: Every write appears on `bus_waddr`/`bus_wdata` with `bus_wvalid` held, unchanged, until `mem_wack`. Memory then holds the written value.
- R5: A read hit raises `core_done` one cycle after the request is accepted, with the stored word, and issues no memory read.
- R6: A read miss raises `mem_rd_req` with the address and never produces a memory write. It returns `mem_rdata` one cycle after `mem_rvalid` and installs the word.
- R7: If a snoop to the requested address arrives in the same cycle as a read is accepted, the read is handled as a miss and goes to memory.
- R8: `core_ready` is low whenever `bus_req` is high, from the accepted write until the cycle after `mem_wack`.
- R9: A write miss updates memory only, so a later read of it misses. A write hit also updates the cached word, so a later read hits with the new value.
- R10: A snoop to the address of a read miss in progress prevents that fill from being installed, so the next read of that address misses again.
- R11: The line index is the low `IDX_W` address bits and the tag is the remaining bits. Two addresses with the same index evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, accepted when `core_ready` is high |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Cache idle and able to accept a request |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read result, valid with `core_done` |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_wvalid | output | 1 | Broadcast write valid |
| bus_waddr | output | ADDR_W | Broadcast write address |
| bus_wdata | output | DATA_W | Broadcast write data |
| mem_wack | input | 1 | Memory write acknowledge |
| mem_rd_req | output | 1 | Memory read request, held until `mem_rvalid` |
| mem_raddr | output | ADDR_W | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DATA_W | Memory read data |
| snp_valid | input | 1 | A peer cache is writing |
| snp_addr | input | ADDR_W | Address written by the peer |

## Verification
The hardest cases to reach are the two snoop races. In the first, a snoop lands in the exact cycle a read is accepted. In the second, a snoop lands while a fill is waiting on memory. The bench reaches both by driving the request and the snoop from the same task on chosen falling edges. Its memory model answers reads a fixed number of cycles later, which keeps the fill window open for a known time. In each race the bench changes its memory image when it raises the snoop. It then checks both the returned word and whether a fresh memory read was issued.

// File: rtl/snp_cache_pkg.sv
package snp_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_WAIT = 2'd1,
    ST_WR_ARB  = 2'd2,
    ST_WR_SEND = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/snp_line_store.sv
module snp_line_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              sn_valid,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_hit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LINES-1:0]  valid_vec
);
  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign valid_vec = valid_q;
  assign lk_hit  = valid_q[idx_of(lk_addr)] && (tag_q[idx_of(lk_addr)] == tag_of(lk_addr));
  assign lk_data = data_q[idx_of(lk_addr)];
  assign sn_hit  = sn_valid && valid_q[idx_of(sn_addr)] &&
                   (tag_q[idx_of(sn_addr)] == tag_of(sn_addr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (sn_hit && idx_of(sn_addr) == IDX_W'(i)) begin
          valid_q[i] <= 1'b0;
        end else if (wr_en && idx_of(wr_addr) == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (wr_en && idx_of(wr_addr) == IDX_W'(i) &&
          !(sn_hit && idx_of(sn_addr) == IDX_W'(i))) begin
        tag_q[i]  <= tag_of(wr_addr);
        data_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/snp_cache_ctl.sv
module snp_cache_ctl
  import snp_cache_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_wvalid,
  output logic [ADDR_W-1:0] bus_waddr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              mem_wack,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic              st_wr_en,
  output logic [ADDR_W-1:0] st_wr_addr,
  output logic [DATA_W-1:0] st_wr_data,
  output logic              rd_hit_fire,
  output logic              rd_miss_start
);
  ctl_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              poison_q;
  logic              accept;
  logic              clash_in;
  logic              clash_q;

  function automatic logic snoop_clash(input logic v, input logic [ADDR_W-1:0] s,
                                       input logic [ADDR_W-1:0] a);
    return v && (s == a);
  endfunction

  assign core_ready    = (state_q == ST_IDLE);
  assign accept        = core_ready && core_req;
  assign clash_in      = snoop_clash(snp_valid, snp_addr, core_addr);
  assign clash_q       = snoop_clash(snp_valid, snp_addr, addr_q);
  assign rd_hit_fire   = accept && !core_we && lk_hit && !clash_in;
  assign rd_miss_start = accept && !core_we && !rd_hit_fire;
  assign lk_addr       = core_ready ? core_addr : addr_q;

  assign bus_req    = (state_q == ST_WR_ARB) || (state_q == ST_WR_SEND);
  assign bus_wvalid = (state_q == ST_WR_SEND);
  assign bus_waddr  = addr_q;
  assign bus_wdata  = data_q;
  assign mem_rd_req = (state_q == ST_RD_WAIT);
  assign mem_raddr  = addr_q;

  always_comb begin
    st_wr_en   = 1'b0;
    st_wr_addr = addr_q;
    st_wr_data = data_q;
    if (state_q == ST_RD_WAIT && mem_rvalid && !poison_q && !clash_q) begin
      st_wr_en   = 1'b1;
      st_wr_data = mem_rdata;
    end else if (state_q == ST_WR_SEND && mem_wack && lk_hit && !clash_q) begin
      st_wr_en   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      poison_q   <= 1'b0;
      core_done  <= 1'b0;
      core_rdata <= '0;
    end else begin
      core_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            addr_q <= core_addr;
            data_q <= core_wdata;
            if (core_we) begin
              state_q <= ST_WR_ARB;
            end else if (rd_hit_fire) begin
              core_done  <= 1'b1;
              core_rdata <= lk_data;
            end else begin
              state_q  <= ST_RD_WAIT;
              poison_q <= 1'b0;
            end
          end
        end
        ST_RD_WAIT: begin
          if (clash_q) poison_q <= 1'b1;
          if (mem_rvalid) begin
            core_done  <= 1'b1;
            core_rdata <= mem_rdata;
            state_q    <= ST_IDLE;
          end
        end
        ST_WR_ARB: begin
          if (bus_gnt) state_q <= ST_WR_SEND;
        end
        ST_WR_SEND: begin
          if (mem_wack) begin
            core_done <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_wvalid,
  output logic [ADDR_W-1:0] bus_waddr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              mem_wack,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr
);
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic [DATA_W-1:0] lk_data;
  logic              snoop_inval;
  logic              st_wr_en;
  logic [ADDR_W-1:0] st_wr_addr;
  logic [DATA_W-1:0] st_wr_data;
  logic [LINES-1:0]  line_valid;
  logic              rd_hit_fire;
  logic              rd_miss_start;

  snp_line_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .sn_valid(snp_valid), .sn_addr(snp_addr), .sn_hit(snoop_inval),
    .wr_en(st_wr_en), .wr_addr(st_wr_addr), .wr_data(st_wr_data),
    .valid_vec(line_valid)
  );

  snp_cache_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_ready(core_ready), .core_done(core_done), .core_rdata(core_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_wvalid(bus_wvalid),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .mem_wack(mem_wack),
    .mem_rd_req(mem_rd_req), .mem_raddr(mem_raddr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
    .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .rd_hit_fire(rd_hit_fire), .rd_miss_start(rd_miss_start)
  );
endmodule

// File: rtl/snp_cache_chk.sv
module snp_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  localparam int LINES = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_req,
  input logic              core_we,
  input logic [ADDR_W-1:0] core_addr,
  input logic              core_ready,
  input logic              core_done,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              bus_wvalid,
  input logic [ADDR_W-1:0] bus_waddr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              mem_wack,
  input logic              mem_rd_req,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snoop_inval,
  input logic [LINES-1:0]  line_valid,
  input logic              rd_hit_fire
);
  assert_wr_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wvalid |-> (bus_req && bus_gnt));

  assert_snoop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_inval |=> !line_valid[$past(snp_addr[IDX_W-1:0])]);

  assert_wr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wvalid && !mem_wack) |=> (bus_wvalid && $stable(bus_waddr) && $stable(bus_wdata)));

  assert_hit_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_fire |=> core_done);

  assert_miss_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !bus_wvalid);

  assert_clash_is_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_ready && core_req && !core_we && snp_valid && snp_addr == core_addr)
      |=> (!core_done && mem_rd_req));

  assert_stall_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !core_ready);
endmodule

bind snoop_wt_cache snp_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
  .core_ready(core_ready), .core_done(core_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_wvalid(bus_wvalid), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
  .mem_wack(mem_wack), .mem_rd_req(mem_rd_req), .snp_valid(snp_valid),
  .snp_addr(snp_addr), .snoop_inval(snoop_inval), .line_valid(line_valid),
  .rd_hit_fire(rd_hit_fire)
);

// File: tb/snoop_wt_cache_tb.sv
module snoop_wt_cache_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int NA = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          core_req = 1'b0, core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_ready, core_done;
  logic [DW-1:0] core_rdata;
  logic          bus_req, bus_wvalid;
  logic          bus_gnt = 1'b0;
  logic [AW-1:0] bus_waddr;
  logic [DW-1:0] bus_wdata;
  logic          mem_wack = 1'b0;
  logic          mem_rd_req;
  logic [AW-1:0] mem_raddr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;

  snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_ready(core_ready),
    .core_done(core_done), .core_rdata(core_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_wvalid(bus_wvalid), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .mem_wack(mem_wack), .mem_rd_req(mem_rd_req),
    .mem_raddr(mem_raddr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr)
  );

  logic [DW-1:0] mem [NA];
  int mem_reads = 0;
  int rd_cnt = 0, gnt_cnt = 0, wr_cnt = 0;
  int checks = 0, fails = 0;

  // memory and arbiter model
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_rd_req && !mem_rvalid) begin
      if (rd_cnt == 2) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_raddr];
        mem_reads  <= mem_reads + 1;
        rd_cnt     <= 0;
      end else rd_cnt <= rd_cnt + 1;
    end
    if (!bus_req) begin
      bus_gnt <= 1'b0; gnt_cnt <= 0;
    end else if (gnt_cnt == 1) bus_gnt <= 1'b1;
    else gnt_cnt <= gnt_cnt + 1;
    mem_wack <= 1'b0;
    if (bus_wvalid && !mem_wack) begin
      if (wr_cnt == 2) begin
        mem_wack <= 1'b1;
        mem[bus_waddr] <= bus_wdata;
        wr_cnt <= 0;
      end else wr_cnt <= wr_cnt + 1;
    end
  end

  int mon_fail_r2 = 0, mon_fail_r6 = 0, mon_fail_r8 = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_wvalid && !bus_gnt) mon_fail_r2++;
      if (mem_rd_req && bus_wvalid) mon_fail_r6++;
      if (bus_req && core_ready) mon_fail_r8++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] f_init(input int a);
    return DW'(a * 3 + 100);
  endfunction

  function automatic logic [DW-1:0] f_wr(input int a, input int k);
    return DW'(a * 37 + 5 + k * 1000);
  endfunction

  task automatic do_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit sn, output logic [DW-1:0] rd, output int nreads,
                       output int lat);
    int r0;
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    r0 = mem_reads;
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    if (sn) begin mem[a] = d; snp_valid = 1'b1; snp_addr = a; end
    @(negedge clk);
    core_req = 1'b0; snp_valid = 1'b0;
    lat = 1;
    while (!core_done) begin @(negedge clk); lat++; end
    rd = core_rdata;
    nreads = mem_reads - r0;
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    mem[a] = d; snp_valid = 1'b1; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic finish_run();
    chk(mon_fail_r2 == 0, "R2 write without grant", mon_fail_r2, 0);
    chk(mon_fail_r6 == 0, "R6 write during read miss", mon_fail_r6, 0);
    chk(mon_fail_r8 == 0, "R8 ready high while bus requested", mon_fail_r8, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int nr, lat;
    for (int a = 0; a < NA; a++) mem[a] = f_init(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_ready == 1'b1, "R1 ready after reset", int'(core_ready), 1);
    chk(!bus_req && !bus_wvalid && !mem_rd_req, "R1 bus idle after reset",
        int'({bus_req, bus_wvalid, mem_rd_req}), 0);

    // R1 R6 R5: every address misses first, then hits
    for (int a = 0; a < NA; a++) begin
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 1, "R1 R6 first read misses", nr, 1);
      chk(rd == f_init(a), "R6 miss data", int'(rd), int'(f_init(a)));
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 0 && lat == 1, "R5 hit no memory read, one cycle", nr * 100 + lat, 1);
      chk(rd == f_init(a), "R5 hit data", int'(rd), int'(f_init(a)));
    end

    // R11: lines now hold addresses 56..63; low addresses were evicted
    for (int a = 0; a < 8; a++) begin
      do_op(1'b0, AW'(a + 56), '0, 1'b0, rd, nr, lat);
      chk(nr == 0, "R11 resident line hits", nr, 0);
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 1, "R11 same-index address evicted", nr, 1);
    end
    // lines now hold 0..7

    // R9 write hit, R4 memory updated, R8 stall
    for (int a = 0; a < 8; a++) begin
      do_op(1'b1, AW'(a), f_wr(a, 1), 1'b0, rd, nr, lat);
      chk(lat >= 5, "R8 write stalls for arbitration and ack", lat, 5);
      chk(mem[a] == f_wr(a, 1), "R4 memory holds write", int'(mem[a]), int'(f_wr(a, 1)));
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 0 && rd == f_wr(a, 1), "R9 write hit updates line", int'(rd), int'(f_wr(a, 1)));
    end

    // R9 write miss: no allocate
    for (int a = 8; a < NA; a++) begin
      do_op(1'b1, AW'(a), f_wr(a, 2), 1'b0, rd, nr, lat);
      chk(mem[a] == f_wr(a, 2), "R4 write miss reaches memory", int'(mem[a]), int'(f_wr(a, 2)));
    end
    for (int a = 8; a < 16; a++) begin
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 1 && rd == f_wr(a, 2), "R9 write miss not allocated", nr, 1);
    end
    // lines now hold 8..15

    // R3 snoop invalidation
    for (int a = 8; a < 16; a++) begin
      snoop(AW'(a), f_wr(a, 3));
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 1, "R3 snooped line misses", nr, 1);
      chk(rd == f_wr(a, 3), "R3 no stale data", int'(rd), int'(f_wr(a, 3)));
    end
    // snoop to a non-resident address with same index leaves line valid
    snoop(AW'(16 + 8), f_wr(24, 3));
    do_op(1'b0, AW'(8), '0, 1'b0, rd, nr, lat);
    chk(nr == 0, "R3 R11 snoop with other tag ignored", nr, 0);

    // R7 same-cycle snoop and read
    for (int a = 8; a < 16; a++) begin
      do_op(1'b0, AW'(a), f_wr(a, 4), 1'b1, rd, nr, lat);
      chk(nr == 1, "R7 clash handled as miss", nr, 1);
      chk(rd == f_wr(a, 4), "R7 clash returns new data", int'(rd), int'(f_wr(a, 4)));
    end

    // R10 snoop during fill
    for (int a = 32; a < 36; a++) begin
      @(negedge clk);
      while (!core_ready) @(negedge clk);
      core_req = 1'b1; core_we = 1'b0; core_addr = AW'(a);
      @(negedge clk);
      core_req = 1'b0;
      mem[a] = f_wr(a, 5); snp_valid = 1'b1; snp_addr = AW'(a);
      @(negedge clk);
      snp_valid = 1'b0;
      while (!core_done) @(negedge clk);
      do_op(1'b0, AW'(a), '0, 1'b0, rd, nr, lat);
      chk(nr == 1, "R10 poisoned fill not installed", nr, 1);
      chk(rd == f_wr(a, 5), "R10 refetch returns new data", int'(rd), int'(f_wr(a, 5)));
    end

    finish_run();
  end
endmodule